// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address used by load and store instructions in a 32-bit RISC pipeline. Each instruction is one 32-bit word, so the block takes everything it needs from a single request. The request carries a mode select, a base register value, an index register value, an immediate field, a scale amount and a valid strobe.

There are four ways to form the address:

- a zero-extended immediate on its own;
- the base plus an unsigned 16-bit offset;
- the base plus the index;
- the base plus the index shifted left by 0 to 3 places.

Every mode produces its result exactly one clock after the request, so the pipeline stage behind the block sees the same fixed latency whatever the mode.

All mode datapaths feed one shared adder. The adder's output is held in an output register that also carries a valid flag. When no request is present, the output register keeps the last address and the valid flag drops.

Top module: `ea_gen`

## Requirements
- R1: A synchronous active-high reset clears the output valid flag on the next clock edge.
- R2: With mode code 2'b00 the address is the immediate field zero-extended, and neither register input affects it. When the width select is 1 the field is taken from bits 15:0. When the width select is 0 it is taken from bits 9:0, and bits 15:10 of the field are ignored.
- R3: With mode code 2'b01 the address is the base plus bits 15:0 of the immediate, zero-extended (an offset of 16'hFFFF adds 65535). The width select has no effect in this mode.
- R4: With mode code 2'b10 the address is the base plus the index.
- R5: With mode code 2'b11 the address is the base plus the index shifted left by the 2-bit scale amount (0, 1, 2 or 3 places).
- R6: All sums are taken modulo 2^32. The carry out is dropped and no flag is raised.
- R7: A request with the valid input high gives the output valid flag high and the address on the output one clock edge later, for every mode, including back-to-back requests in different modes.
- R8: After a clock edge where the valid input is low, the output valid flag is low and the address output keeps its previous value.
- R9: The scale amount has no effect in modes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request valid |
| in_mode | input | 2 | Addressing mode code |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_imm | input | 16 | Immediate field |
| in_imm_wide | input | 1 | 1: 16-bit immediate, 0: 10-bit immediate (mode 2'b00 only) |
| in_scale | input | 2 | Left-shift amount for the index in mode 2'b11 |
| out_vld | output | 1 | Address valid |
| out_addr | output | 32 | Effective address |

## Verification
The bench sets the top bit of the 16-bit offset, so that a design which sign-extends it yields an address 64 KiB too low. In 10-bit immediate mode it fills bits 15:10 with ones to expose a design that leaks them into the address. The scaled mode is driven through every shift amount, and a non-zero scale is also sent in each of the other modes, to catch a shifter that is applied to the wrong mode. Sums that pass 2^32, idle cycles placed between requests, and back-to-back requests in mixed modes then check for wrap errors, for an address that changes while no request is valid, and for a latency that depends on the mode.

// File: rtl/ea_pkg.sv
package ea_pkg;

    parameter int ADDR_W      = 32;
    parameter int IMM_W       = 16;
    parameter int SHORT_IMM_W = 10;
    parameter int SCALE_W     = 2;
    localparam int NUM_SCALES = 1 << SCALE_W;

    typedef enum logic [1:0] {
        AM_IMM  = 2'b00,
        AM_BOFS = 2'b01,
        AM_BIDX = 2'b10,
        AM_BSCL = 2'b11
    } ea_mode_t;

    typedef struct packed {
        ea_mode_t              mode;
        logic [ADDR_W-1:0]     base;
        logic [ADDR_W-1:0]     index;
        logic [IMM_W-1:0]      imm;
        logic                  wide;
        logic [SCALE_W-1:0]    scale;
    } ea_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lhs;
        logic [ADDR_W-1:0] rhs;
    } ea_opnd_t;

    // Zero-extend the immediate; a narrow field keeps only its low bits.
    function automatic logic [ADDR_W-1:0] zext_imm(input logic [IMM_W-1:0] imm,
                                                   input logic wide);
        logic [ADDR_W-1:0] v;
        v = '0;
        v[IMM_W-1:0] = imm;
        if (!wide) v[ADDR_W-1:SHORT_IMM_W] = '0;
        return v;
    endfunction

    // Offset for register-plus-immediate: always the full field, unsigned.
    function automatic logic [ADDR_W-1:0] zext_ofs(input logic [IMM_W-1:0] imm);
        logic [ADDR_W-1:0] v;
        v = '0;
        v[IMM_W-1:0] = imm;
        return v;
    endfunction

endpackage

// File: rtl/ea_operand_sel.sv
module ea_operand_sel
    import ea_pkg::*;
(
    input  ea_req_t  req,
    output ea_opnd_t opnd
);

    logic [ADDR_W-1:0] shifted [NUM_SCALES];
    logic [ADDR_W-1:0] scaled_idx;

    // One candidate per shift amount; the scale field picks one.
    for (genvar g = 0; g < NUM_SCALES; g++) begin : g_shift
        assign shifted[g] = req.index << g;
    end

    assign scaled_idx = shifted[req.scale];

    always_comb begin
        unique case (req.mode)
            AM_IMM: begin
                opnd.lhs = '0;
                opnd.rhs = zext_imm(req.imm, req.wide);
            end
            AM_BOFS: begin
                opnd.lhs = req.base;
                opnd.rhs = zext_ofs(req.imm);
            end
            AM_BIDX: begin
                opnd.lhs = req.base;
                opnd.rhs = req.index;
            end
            default: begin
                opnd.lhs = req.base;
                opnd.rhs = scaled_idx;
            end
        endcase
    end

endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);

    // Modulo 2^W: carry out is dropped.
    assign sum = a + b;

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         d_vld,
    input  logic [W-1:0] d_addr,
    output logic         q_vld,
    output logic [W-1:0] q_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_vld  <= 1'b0;
            q_addr <= '0;
        end else begin
            q_vld <= d_vld;
            if (d_vld) q_addr <= d_addr;
        end
    end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [1:0]          in_mode,
    input  logic [ADDR_W-1:0]   in_base,
    input  logic [ADDR_W-1:0]   in_index,
    input  logic [IMM_W-1:0]    in_imm,
    input  logic                in_imm_wide,
    input  logic [SCALE_W-1:0]  in_scale,
    output logic                out_vld,
    output logic [ADDR_W-1:0]   out_addr
);

    ea_req_t           req;
    ea_opnd_t          opnd;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        req.mode  = ea_mode_t'(in_mode);
        req.base  = in_base;
        req.index = in_index;
        req.imm   = in_imm;
        req.wide  = in_imm_wide;
        req.scale = in_scale;
    end

    ea_operand_sel u_sel (
        .req  (req),
        .opnd (opnd)
    );

    ea_adder #(.W(ADDR_W)) u_add (
        .a   (opnd.lhs),
        .b   (opnd.rhs),
        .sum (sum)
    );

    ea_out_stage #(.W(ADDR_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .d_vld  (in_vld),
        .d_addr (sum),
        .q_vld  (out_vld),
        .q_addr (out_addr)
    );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [1:0]          in_mode,
    input  logic [ADDR_W-1:0]   in_base,
    input  logic [ADDR_W-1:0]   in_index,
    input  logic [IMM_W-1:0]    in_imm,
    input  logic                in_imm_wide,
    input  logic [SCALE_W-1:0]  in_scale,
    input  logic                out_vld,
    input  logic [ADDR_W-1:0]   out_addr
);

    // R1
    rst_clears_vld_chk: assert property (@(posedge clk) rst |=> !out_vld);

    // R7
    vld_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R8
    idle_drops_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R8
    idle_holds_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_vld && !$past(rst)) |=> $stable(out_addr));

    // R2
    short_imm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_mode == 2'b00 && !in_imm_wide) |=> out_addr[ADDR_W-1:SHORT_IMM_W] == '0);

    // R4
    base_idx_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_mode == 2'b10) |=> out_addr == ($past(in_base) + $past(in_index)));

    // R3
    base_ofs_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_mode == 2'b01) |=>
            out_addr == ($past(in_base) + {{(ADDR_W-IMM_W){1'b0}}, $past(in_imm)}));

    // R5
    unscaled_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_mode == 2'b11 && in_scale == '0) |=>
            out_addr == ($past(in_base) + $past(in_index)));

endmodule

bind ea_gen ea_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_vld      (in_vld),
    .in_mode     (in_mode),
    .in_base     (in_base),
    .in_index    (in_index),
    .in_imm      (in_imm),
    .in_imm_wide (in_imm_wide),
    .in_scale    (in_scale),
    .out_vld     (out_vld),
    .out_addr    (out_addr)
);

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [1:0]  in_mode;
    logic [31:0] in_base;
    logic [31:0] in_index;
    logic [15:0] in_imm;
    logic        in_imm_wide;
    logic [1:0]  in_scale;
    logic        out_vld;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ea_gen u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
        .in_base(in_base), .in_index(in_index), .in_imm(in_imm),
        .in_imm_wide(in_imm_wide), .in_scale(in_scale),
        .out_vld(out_vld), .out_addr(out_addr)
    );

    function automatic logic [31:0] model(input logic [1:0] m, input logic [31:0] b,
                                          input logic [31:0] x, input logic [15:0] i,
                                          input logic w, input logic [1:0] s);
        case (m)
            2'b00:   return w ? {16'h0, i} : {22'h0, i[9:0]};
            2'b01:   return b + {16'h0, i};
            2'b10:   return b + x;
            default: return b + (x << s);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request, step one clock, sample 1 ns after the edge.
    task automatic issue(input logic [1:0] m, input logic [31:0] b, input logic [31:0] x,
                         input logic [15:0] i, input logic w, input logic [1:0] s);
        in_vld = 1'b1; in_mode = m; in_base = b; in_index = x;
        in_imm = i; in_imm_wide = w; in_scale = s;
        @(posedge clk); #1;
    endtask

    task automatic issue_chk(input string tag, input logic [1:0] m, input logic [31:0] b,
                             input logic [31:0] x, input logic [15:0] i, input logic w,
                             input logic [1:0] s);
        issue(m, b, x, i, w, s);
        check({tag, " vld"}, {31'h0, out_vld}, 32'h1);
        check(tag, out_addr, model(m, b, x, i, w, s));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_vld = 1'b1;
        @(posedge clk); #1;
        check("R1 reset vld", {31'h0, out_vld}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_imm;
        issue_chk("R2 wide imm", 2'b00, 32'hDEAD_BEEF, 32'h1234_5678, 16'hF00D, 1'b1, 2'd3);
        issue_chk("R2 short imm", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, 2'd2);
        check("R2 short imm literal", out_addr, 32'h0000_03FF);
    endtask

    task automatic t_ofs;
        issue_chk("R3 unsigned ofs", 2'b01, 32'h0001_0000, 32'h0, 16'hFFFF, 1'b0, 2'd0);
        check("R3 ofs literal", out_addr, 32'h0001_FFFF);
        issue_chk("R9 scale in mode01", 2'b01, 32'h0000_1000, 32'h7, 16'h0010, 1'b1, 2'd3);
    endtask

    task automatic t_idx;
        issue_chk("R4 base+idx", 2'b10, 32'h1000_0000, 32'h0000_0ABC, 16'h5555, 1'b0, 2'd0);
        issue_chk("R9 scale in mode10", 2'b10, 32'h0000_0100, 32'h0000_0004, 16'h0, 1'b1, 2'd2);
        check("R9 mode10 literal", out_addr, 32'h0000_0104);
    endtask

    task automatic t_scl;
        for (int s = 0; s < 4; s++)
            issue_chk($sformatf("R5 scale %0d", s), 2'b11, 32'h0000_4000, 32'h0000_0003,
                      16'hFFFF, 1'b1, 2'(s));
        check("R5 scale3 literal", out_addr, 32'h0000_4018);
    endtask

    task automatic t_wrap;
        issue_chk("R6 wrap idx", 2'b10, 32'hFFFF_FFF0, 32'h0000_0020, 16'h0, 1'b0, 2'd0);
        check("R6 wrap literal", out_addr, 32'h0000_0010);
        issue_chk("R6 wrap scl", 2'b11, 32'h8000_0000, 32'h4000_0000, 16'h0, 1'b0, 2'd3);
        issue_chk("R6 wrap ofs", 2'b01, 32'hFFFF_FFFF, 32'h0, 16'h0002, 1'b0, 2'd0);
    endtask

    task automatic t_idle;
        logic [31:0] held;
        issue_chk("R8 before idle", 2'b10, 32'h0000_2000, 32'h0000_0022, 16'h0, 1'b0, 2'd0);
        held = out_addr;
        in_vld = 1'b0; in_base = 32'hAAAA_AAAA; in_index = 32'h5555_5555; in_mode = 2'b10;
        @(posedge clk); #1;
        check("R8 idle vld", {31'h0, out_vld}, 32'h0);
        check("R8 idle hold", out_addr, held);
        @(posedge clk); #1;
        check("R8 idle hold 2", out_addr, held);
    endtask

    task automatic t_b2b;
        issue_chk("R7 b2b imm", 2'b00, 32'h0, 32'h0, 16'h0123, 1'b1, 2'd0);
        issue_chk("R7 b2b scl", 2'b11, 32'h0000_0010, 32'h0000_0001, 16'h0, 1'b0, 2'd2);
        issue_chk("R7 b2b ofs", 2'b01, 32'h0000_0020, 32'h0, 16'h0008, 1'b0, 2'd1);
        issue_chk("R7 b2b idx", 2'b10, 32'h0000_0030, 32'h0000_0003, 16'h0, 1'b1, 2'd1);
    endtask

    task automatic t_reset_mid;
        issue_chk("R1 pre reset", 2'b10, 32'h1, 32'h1, 16'h0, 1'b0, 2'd0);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 mid reset vld", {31'h0, out_vld}, 32'h0);
        rst = 1'b0; in_vld = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        in_vld = 1'b0; in_mode = 2'b00; in_base = '0; in_index = '0;
        in_imm = '0; in_imm_wide = 1'b0; in_scale = '0; rst = 1'b1;
        @(posedge clk); #1;
        t_reset;
        t_imm;
        t_ofs;
        t_idx;
        t_scl;
        t_wrap;
        t_idle;
        t_b2b;
        t_reset_mid;
        finish_run;
    end

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run;
    end

endmodule